// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns machine-cycle requests from an 8-bit processor core into external bus cycles on a bus that shares its low address byte with data. Each cycle steps through T-states at one T-state per clock. In T1 the full address appears and a latch-enable strobe marks the low byte. In the middle states a read, write or interrupt-acknowledge strobe is asserted and data moves. Opcode fetches take one extra T-state. A three-bit status code gives the cycle type for the whole cycle. READY stretches the strobe phase with wait states.

Between cycles the sequencer honours a bus-hold request. It floats every address, data and control output and answers with a hold acknowledge. A halt request parks the sequencer in a low-power state that keeps the last transferred byte on the bus. Halt is left through an interrupt wake input. If hold is taken while halted, halt is left only by dropping hold.

The core side is a level request with kind, address and write data, which is answered by a one-cycle done pulse carrying read data. Tri-state pins are modelled as separate value and output-enable signals.

Top module: `mbus_seq`

## Requirements
- R1: In T1 (the first clock after a request is accepted), `ale`=1, `ad_oe`=1, `ad_out` = address bits 7:0 and `a_hi` = address bits 15:8. `ale` is 0 in every other clock.
- R2: `{io_m,s1,s0}` by request kind code: opcode fetch (0) = 011, memory read (1) = 010, memory write (2) = 001, I/O read (3) = 110, I/O write (4) = 101, interrupt acknowledge (5) = 111, bus idle (6) = 010.
- R3: The status code and `io_m_oe`=`s_oe`=1 stay constant from T1 through the last T-state of the cycle.
- R4: Active-low strobes run from T2 through T3, including wait states. `rd_n` is used for kinds 0, 1, 3 and 6 is excluded, `wr_n` for kinds 2 and 4, `inta_n` for kind 5. Bus idle (6) asserts no strobe. At most one strobe is low at any time.
- R5: A cycle is T1, T2, wait states, T3, plus T4 for opcode fetch only. `req_done` is a one-clock pulse in the clock after the last T-state. A request is never accepted in a clock where `req_done` is high.
- R6: `ready` is sampled at the end of T2 and of each wait state. Each low sample adds one wait state with the strobe held low.
- R7: Writes drive `req_wdata` on `ad_out` with `ad_oe`=1 from T2 through T3. Other kinds release the bus (`ad_oe`=0) there, and `rd_data` equals `ad_in` sampled at the end of T3 and is valid with `req_done`.
- R8: `hold` is acted on only between cycles, and a cycle in progress completes. While held, `hlda`=1 and `a_hi_oe`, `ad_oe`, `ctl_oe`, `io_m_oe`, `s_oe` are 0. One clock after `hold` drops, `hlda`=0.
- R9: Kind 7 enters halt. In halt, `halted`=1, `s1`=`s0`=0, `io_m_oe`=0, all strobes are inactive, and `ad_oe`=1 with `ad_out` holding the last T3 byte (write data for writes, the captured `ad_in` otherwise).
- R10: In halt without hold, `wake`=1 ends halt. The next clock is idle with `req_done`=1 and `halted`=0.
- R11: If `hold` rises during halt, the bus floats with `hlda`=1, `wake` is ignored, and dropping `hold` ends halt with a `req_done` pulse.
- R12: After reset, no strobe or `ale` is active, and `hlda`, `req_done` and `halted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_done | output | 1 | Cycle finished pulse |
| rd_data | output | 8 | Byte captured at end of T3 |
| ready | input | 1 | Wait-state control |
| hold | input | 1 | External bus-hold request |
| wake | input | 1 | Interrupt wake from halt |
| ad_in | input | 8 | Low bus sampled value |
| ad_out | output | 8 | Low bus driven value |
| ad_oe | output | 1 | Low bus drive enable |
| a_hi | output | 8 | High address byte |
| a_hi_oe | output | 1 | High address drive enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| ctl_oe | output | 1 | Strobe drive enable |
| io_m | output | 1 | I/O-not-memory status |
| io_m_oe | output | 1 | `io_m` drive enable |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| s_oe | output | 1 | `s1`/`s0` drive enable |
| hlda | output | 1 | Hold acknowledge |
| halted | output | 1 | Halt power-down active |

## Verification
The bench mixes random kinds, addresses, data and wait counts with directed opcode fetches, bus-idle cycles and long waits. A sequencer that miscounts T-states or waits would move the done pulse or the strobe edges one clock. One that loaded the wrong kind would show a wrong status or strobe. Hold is raised in the middle of a cycle, so a design that floated the bus early would cut the strobe short and lose the done pulse. The halt cases check that the byte retained on the bus is the last write or read value. They also check that wake is obeyed in plain halt and ignored once hold has been taken, where a mixed-up release rule would leave halt at the wrong moment.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_IACK  = 3'd5,
        K_IDLE  = 3'd6,
        K_HALT  = 3'd7
    } bus_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_T1       = 4'd1,
        ST_T2       = 4'd2,
        ST_TW       = 4'd3,
        ST_T3       = 4'd4,
        ST_T4       = 4'd5,
        ST_HALT     = 4'd6,
        ST_HOLD     = 4'd7,
        ST_HALTHOLD = 4'd8
    } seq_state_e;

    function automatic logic kind_writes(input bus_kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    // {io_m, s1, s0}
    function automatic logic [2:0] kind_status(input bus_kind_e k);
        case (k)
            K_FETCH: return 3'b011;
            K_MRD:   return 3'b010;
            K_MWR:   return 3'b001;
            K_IORD:  return 3'b110;
            K_IOWR:  return 3'b101;
            K_IACK:  return 3'b111;
            K_IDLE:  return 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic in_strobe_phase(input seq_state_e s);
        return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
    endfunction

    function automatic logic in_bus_cycle(input seq_state_e s);
        return (s == ST_T1) || in_strobe_phase(s) || (s == ST_T4);
    endfunction

endpackage

// File: rtl/mbus_seq_fsm.sv
module mbus_seq_fsm
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold,
    input  logic              wake,
    input  logic [DATA_W-1:0] ad_in,
    output seq_state_e        st,
    output bus_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] keep,
    output logic              done
);

    typedef struct packed {
        seq_state_e        st;
        bus_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] keep;
        logic              done;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (hold) begin
                    seq_d.st = ST_HOLD;
                end else if (req_valid && !seq_q.done) begin
                    seq_d.kind  = bus_kind_e'(req_kind);
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.st    = (bus_kind_e'(req_kind) == K_HALT) ? ST_HALT : ST_T1;
                end
            end
            ST_T1: seq_d.st = ST_T2;
            ST_T2, ST_TW: seq_d.st = ready ? ST_T3 : ST_TW;
            ST_T3: begin
                if (kind_writes(seq_q.kind)) begin
                    seq_d.keep = seq_q.wdata;
                end else begin
                    seq_d.keep  = ad_in;
                    seq_d.rdata = ad_in;
                end
                if (seq_q.kind == K_FETCH) begin
                    seq_d.st = ST_T4;
                end else begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            ST_T4: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            ST_HALT: begin
                if (wake) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else if (hold) begin
                    seq_d.st = ST_HALTHOLD;
                end
            end
            ST_HOLD: begin
                if (!hold) seq_d.st = ST_IDLE;
            end
            ST_HALTHOLD: begin
                if (!hold) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.kind  <= K_IDLE;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
            seq_q.rdata <= '0;
            seq_q.keep  <= '0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st    = seq_q.st;
    assign kind  = seq_q.kind;
    assign addr  = seq_q.addr;
    assign wdata = seq_q.wdata;
    assign rdata = seq_q.rdata;
    assign keep  = seq_q.keep;
    assign done  = seq_q.done;

    // R6: a low READY sample in T2 or a wait state yields another wait state
    p_wait_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_T2 || seq_q.st == ST_TW) && !ready) |=> (seq_q.st == ST_TW));

    // R5: done lasts exactly one clock, and no request is taken while it is high
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);
    p_no_accept_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && seq_q.done && !hold) |=> (seq_q.st == ST_IDLE));

    // R10: wake releases a plain halt
    p_halt_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HALT && wake) |=> (seq_q.st == ST_IDLE && seq_q.done));

    // R11: once hold is taken in halt, only dropping hold leaves
    p_halthold_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HALTHOLD && hold) |=> (seq_q.st == ST_HALTHOLD));

endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e st,
    input  bus_kind_e  kind,
    output logic       ale,
    output logic       rd_n,
    output logic       wr_n,
    output logic       inta_n,
    output logic       ctl_oe,
    output logic       io_m,
    output logic       io_m_oe,
    output logic       s1,
    output logic       s0,
    output logic       s_oe,
    output logic       hlda,
    output logic       halted
);

    logic       floated;
    logic       strobing;
    logic [2:0] code;

    always_comb begin
        floated  = (st == ST_HOLD) || (st == ST_HALTHOLD);
        strobing = in_strobe_phase(st);
        code     = kind_status(kind);

        ale    = (st == ST_T1);
        rd_n   = !(strobing && (kind == K_FETCH || kind == K_MRD || kind == K_IORD));
        wr_n   = !(strobing && kind_writes(kind));
        inta_n = !(strobing && kind == K_IACK);
        ctl_oe = !floated;
        hlda   = floated;
        halted = (st == ST_HALT) || (st == ST_HALTHOLD);

        if (st == ST_HALT || st == ST_HALTHOLD) begin
            io_m = 1'b0;
            s1   = 1'b0;
            s0   = 1'b0;
        end else begin
            io_m = code[2];
            s1   = code[1];
            s0   = code[0];
        end
        io_m_oe = !floated && !halted;
        s_oe    = !floated;
    end

    // R4: never two strobes at once
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

    // R3: status frozen after T1 until the cycle ends
    p_status_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe_phase(st) || st == ST_T4) |-> $stable({io_m, s1, s0}));

endmodule

// File: rtl/mbus_pad_ctl.sv
module mbus_pad_ctl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  seq_state_e        st,
    input  bus_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] keep,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              a_hi_oe
);

    always_comb begin
        a_hi    = addr[ADDR_W-1:DATA_W];
        a_hi_oe = !(st == ST_HOLD || st == ST_HALTHOLD);
        ad_out  = keep;
        ad_oe   = 1'b0;
        if (st == ST_T1) begin
            ad_out = addr[DATA_W-1:0];
            ad_oe  = 1'b1;
        end else if (in_strobe_phase(st) && kind_writes(kind)) begin
            ad_out = wdata;
            ad_oe  = 1'b1;
        end else if (st == ST_HALT) begin
            ad_out = keep;
            ad_oe  = 1'b1;
        end
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ready,
    input  logic              hold,
    input  logic              wake,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              a_hi_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              ctl_oe,
    output logic              io_m,
    output logic              io_m_oe,
    output logic              s1,
    output logic              s0,
    output logic              s_oe,
    output logic              hlda,
    output logic              halted
);

    seq_state_e        st;
    bus_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] keep;

    mbus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .hold      (hold),
        .wake      (wake),
        .ad_in     (ad_in),
        .st        (st),
        .kind      (kind),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rd_data),
        .keep      (keep),
        .done      (req_done)
    );

    mbus_strobe_gen u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .kind    (kind),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n),
        .ctl_oe  (ctl_oe),
        .io_m    (io_m),
        .io_m_oe (io_m_oe),
        .s1      (s1),
        .s0      (s0),
        .s_oe    (s_oe),
        .hlda    (hlda),
        .halted  (halted)
    );

    mbus_pad_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pad (
        .st      (st),
        .kind    (kind),
        .addr    (addr),
        .wdata   (wdata),
        .keep    (keep),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_hi    (a_hi),
        .a_hi_oe (a_hi_oe)
    );

    // R8: acknowledge only with every driver released
    p_hold_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !a_hi_oe && !ctl_oe && !io_m_oe && !s_oe));

    // R1: latch enable is a single-clock pulse
    p_ale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R9: halt shows no strobe and status 00
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !hlda) |-> (rd_n && wr_n && inta_n && !s1 && !s0 && ad_oe));

endmodule

// File: tb/test_mbus_seq.sv
`timescale 1ns/1ps
module test_mbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_done;
    logic [7:0]  rd_data;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        wake = 1'b0;
    logic [7:0]  ad_in = 8'h0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  a_hi;
    logic        a_hi_oe;
    logic        ale, rd_n, wr_n, inta_n, ctl_oe;
    logic        io_m, io_m_oe, s1, s0, s_oe, hlda, halted;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] last_t3 = 8'h0;

    always #4 clk = ~clk;

    mbus_seq i_mbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .rd_data(rd_data), .ready(ready), .hold(hold), .wake(wake),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
        .a_hi_oe(a_hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .ctl_oe(ctl_oe), .io_m(io_m), .io_m_oe(io_m_oe),
        .s1(s1), .s0(s0), .s_oe(s_oe), .hlda(hlda), .halted(halted)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            3'd5: return 3'b111;
            3'd6: return 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    // active strobes as {rd, wr, inta}
    function automatic logic [2:0] exp_strobe(input logic [2:0] k);
        case (k)
            3'd0, 3'd1, 3'd3: return 3'b100;
            3'd2, 3'd4:       return 3'b010;
            3'd5:             return 3'b001;
            default:          return 3'b000;
        endcase
    endfunction

    function automatic logic is_wr(input logic [2:0] k);
        return (k == 3'd2) || (k == 3'd4);
    endfunction

    task automatic bus_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rv, input int waits, input bit hold_mid);
        int ntot;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; ad_in = rv;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 ale in T1", ale, 1);
        chk("R1 low address", ad_out, a[7:0]);
        chk("R1 low bus driven", ad_oe, 1);
        chk("R1 high address", a_hi, a[15:8]);
        chk("R2 status code", {io_m, s1, s0}, exp_status(k));
        chk("R3 status enables", {io_m_oe, s_oe}, 2'b11);
        ntot = 3 + waits + ((k == 3'd0) ? 1 : 0);
        for (int i = 1; i <= ntot; i++) begin
            @(negedge clk);
            ready = (i >= 1 && i <= waits) ? 1'b0 : 1'b1;
            if (i == 1 && hold_mid) hold = 1'b1;
            if (i < ntot) begin
                chk("R5 no early done", req_done, 0);
                chk("R1 ale low", ale, 0);
                chk("R4 R6 strobes", {~rd_n, ~wr_n, ~inta_n},
                    (i <= waits + 2) ? exp_strobe(k) : 3'b000);
                chk("R3 status held", {io_m, s1, s0}, exp_status(k));
                chk("R8 no early hlda", hlda, 0);
                if (i <= waits + 2) begin
                    if (is_wr(k)) begin
                        chk("R7 write drive", ad_oe, 1);
                        chk("R7 write data", ad_out, wd);
                    end else begin
                        chk("R7 read release", ad_oe, 0);
                    end
                end
            end else begin
                chk("R5 done pulse", req_done, 1);
                if (!is_wr(k)) chk("R7 read data", rd_data, rv);
            end
        end
        ready = 1'b1;
        last_t3 = is_wr(k) ? wd : rv;
    endtask

    task automatic enter_halt();
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd7; req_addr = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 strobes idle", {ale, rd_n, wr_n, inta_n}, 4'b0111);
        chk("R12 hlda/done/halted", {hlda, req_done, halted}, 3'b000);

        // directed: every kind once, plus long waits
        bus_cycle(3'd0, 16'hA1B2, 8'h00, 8'h3E, 0, 0);
        bus_cycle(3'd0, 16'h0F0F, 8'h00, 8'h76, 2, 0);
        bus_cycle(3'd1, 16'h8000, 8'h00, 8'hC3, 3, 0);
        bus_cycle(3'd2, 16'h7FFF, 8'h5A, 8'h00, 0, 0);
        bus_cycle(3'd3, 16'h00FE, 8'h00, 8'h81, 1, 0);
        bus_cycle(3'd4, 16'h0042, 8'hE7, 8'h00, 4, 0);
        bus_cycle(3'd5, 16'hFFFF, 8'h00, 8'hCF, 0, 0);
        bus_cycle(3'd6, 16'h4321, 8'h00, 8'h19, 1, 0);

        // random mix
        for (int n = 0; n < 60; n++) begin
            bus_cycle(3'($urandom_range(0, 6)), 16'($urandom), 8'($urandom),
                      8'($urandom), int'($urandom_range(0, 3)), 0);
        end

        // R8: hold raised mid cycle, cycle still completes, then float
        bus_cycle(3'd1, 16'h2468, 8'h00, 8'h99, 1, 1);
        @(negedge clk);
        chk("R8 hlda", hlda, 1);
        chk("R8 float", {a_hi_oe, ad_oe, ctl_oe, io_m_oe, s_oe}, 5'b00000);
        @(negedge clk);
        chk("R8 stays held", hlda, 1);
        hold = 1'b0;
        @(negedge clk);
        chk("R8 hlda released", hlda, 0);
        bus_cycle(3'd2, 16'h1357, 8'hA5, 8'h00, 0, 0);

        // R9/R10: halt retains the written byte, wake releases
        enter_halt();
        chk("R9 halted", halted, 1);
        chk("R9 status 00", {s1, s0}, 2'b00);
        chk("R9 io_m released", io_m_oe, 0);
        chk("R9 strobes idle", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R9 retained byte", {ad_oe, ad_out}, {1'b1, 8'hA5});
        @(negedge clk);
        chk("R9 still halted", halted, 1);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        chk("R10 done on wake", req_done, 1);
        chk("R10 halt left", halted, 0);

        // R9 after a read, then R11 halt with hold
        bus_cycle(3'd1, 16'h5555, 8'h00, 8'h3C, 0, 0);
        enter_halt();
        chk("R9 retained read byte", {ad_oe, ad_out}, {1'b1, 8'h3C});
        hold = 1'b1;
        @(negedge clk);
        chk("R11 hlda", hlda, 1);
        chk("R11 float", {a_hi_oe, ad_oe, ctl_oe, io_m_oe, s_oe}, 5'b00000);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        chk("R11 wake ignored", {halted, req_done}, 2'b10);
        hold = 1'b0;
        @(negedge clk);
        chk("R11 release by hold drop", {req_done, halted, hlda}, 3'b100);

        bus_cycle(3'd0, 16'h9ABC, 8'h00, 8'h55, 0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule